// File: doc/BRIEF.md
# Sample FIFO with Status Flags

This block buffers acceleration samples between a producer that delivers one sample per write strobe and a consumer that pops one sample per register read. The oldest stored sample is always presented on the read data port, so a read request both returns that sample and removes it. Three status outputs describe the queue: a ready flag when something can be read, a watermark flag against a programmable fill threshold, and a sticky overrun flag that records lost data.

A single configuration write loads the operating mode and the watermark threshold. The threshold is nine bits wide. Its low eight bits come from a count field and its top bit comes from a separate control bit. The threshold resets to 128 so that the watermark does not fire out of reset. Two full-queue policies exist. Streaming mode keeps the newest data by discarding the oldest entry. Oldest-saved mode keeps what is stored and drops the newcomer.

The controller is a three-state machine. ST_OFF holds the queue empty and ignores traffic. ST_STREAM is the overwrite policy. ST_KEEP is the drop-new policy. Every configuration write moves the machine to the state its mode field selects. This covers OFF to STREAM, OFF to KEEP, STREAM to KEEP, KEEP to STREAM, and either running state back to OFF. With no configuration write, the state holds.

Top module: `sample_fifo`

## Requirements
- R1: After reset the mode is off, the threshold is 128, and ready, watermark and overrun are all low.
- R2: ready is high exactly when the mode is not off and at least one sample is stored. rd_req is only accepted while ready is high.
- R3: Samples leave in arrival order, and rd_data always shows the oldest stored sample while ready is high.
- R4: watermark is high whenever the stored count is at least the threshold {cfg_wm_hi, cfg_samples}. It falls by itself once reads bring the count below the threshold.
- R5: A threshold of 0 holds watermark high even when the queue is empty.
- R6: In streaming mode, a write into a full queue with no accepted read discards the oldest sample and stores the new one. The count stays at DEPTH and overrun is set.
- R7: In oldest-saved mode, a write into a full queue with no accepted read discards the new sample, leaves the contents unchanged and sets overrun.
- R8: An accepted read together with a write on a full queue is an ordinary transfer and never sets overrun.
- R9: An accepted read clears overrun at the same clock edge.
- R10: From the second edge after the mode is set to off, the queue is empty and overrun is low. Writes and reads have no effect while the mode is off.
- R11: The cfg_mode encoding is 2'b00 = off, 2'b01 = streaming, 2'b10 = oldest-saved and 2'b11 = streaming. It takes effect at the edge of cfg_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load mode and threshold |
| cfg_mode | input | 2 | Mode field (R11 encoding) |
| cfg_wm_hi | input | 1 | Threshold bit 8 |
| cfg_samples | input | 8 | Threshold bits 7:0 |
| wr_valid | input | 1 | Push one sample |
| wr_data | input | DW | Sample to push |
| rd_req | input | 1 | Pop the oldest sample |
| rd_data | output | DW | Oldest stored sample |
| ready | output | 1 | At least one sample readable |
| watermark | output | 1 | Count at or above threshold |
| overrun | output | 1 | Data lost since last read |

## Verification
The bench fills the queue to exactly DEPTH and then keeps writing in both modes. If streaming mode dropped the new sample, or oldest-saved mode overwrote the head, a later rd_data would show the wrong value.

It also drives a read and a write together on a full queue. A design that treated this as an overflow would raise overrun falsely.

The threshold is swept across 5, 0 and 511. Here an off-by-one compare, or a missing top threshold bit, would move the watermark edge by one sample or by 256.

The bench disables the queue while overrun is set and data is stored. A design that only stopped traffic, without flushing, would later show stale data or a stuck overrun.

// File: rtl/sample_fifo_pkg.sv
package sample_fifo_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'b00,
        ST_STREAM = 2'b01,
        ST_KEEP   = 2'b10
    } fifo_state_t;

    function automatic fifo_state_t mode_to_state(input logic [1:0] m);
        fifo_state_t s;
        unique case (m)
            2'b00:   s = ST_OFF;
            2'b10:   s = ST_KEEP;
            default: s = ST_STREAM;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/sample_fifo_store.sv
module sample_fifo_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sample_fifo_ctrl.sv
module sample_fifo_ctrl
    import sample_fifo_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_mode,
    input  logic          wr_valid,
    input  logic          rd_req,
    output fifo_state_t   state,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          mem_we,
    output logic          overrun
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    fifo_state_t   state_q;
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          ovr_q;

    logic full, rd_ok, flush, adv_wr, adv_rd, ovr_set, ovr_clr, we_c;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    // State register: every configuration write picks the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else if (cfg_wr) begin
            state_q <= mode_to_state(cfg_mode);
        end
    end

    // Per-state actions.
    always_comb begin
        full    = (count_q == FULL_CNT);
        rd_ok   = rd_req && (count_q != '0);
        flush   = 1'b0;
        adv_wr  = 1'b0;
        adv_rd  = 1'b0;
        ovr_set = 1'b0;
        ovr_clr = 1'b0;
        we_c    = 1'b0;
        unique case (state_q)
            ST_STREAM: begin
                we_c    = wr_valid;
                adv_wr  = wr_valid;
                adv_rd  = rd_ok || (wr_valid && full);
                ovr_set = wr_valid && full && !rd_ok;
                ovr_clr = rd_ok;
            end
            ST_KEEP: begin
                we_c    = wr_valid && (!full || rd_ok);
                adv_wr  = we_c;
                adv_rd  = rd_ok;
                ovr_set = wr_valid && full && !rd_ok;
                ovr_clr = rd_ok;
            end
            default: begin
                flush = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            ovr_q    <= 1'b0;
        end else begin
            if (adv_wr) wr_ptr_q <= bump(wr_ptr_q);
            if (adv_rd) rd_ptr_q <= bump(rd_ptr_q);
            count_q <= count_q + CW'(adv_wr) - CW'(adv_rd);
            if (ovr_set) begin
                ovr_q <= 1'b1;
            end else if (ovr_clr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign state   = state_q;
    assign wr_ptr  = wr_ptr_q;
    assign rd_ptr  = rd_ptr_q;
    assign count   = count_q;
    assign mem_we  = we_c;
    assign overrun = ovr_q;
endmodule

// File: rtl/sample_fifo_flags.sv
module sample_fifo_flags
    import sample_fifo_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int TW    = 9,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  fifo_state_t   state,
    input  logic [CW-1:0] count,
    input  logic [TW-1:0] thr,
    output logic          ready,
    output logic          watermark
);
    localparam int XW = (CW > TW) ? CW : TW;

    assign ready     = (count != '0) && (state != ST_OFF);
    assign watermark = XW'(count) >= XW'(thr);
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
    import sample_fifo_pkg::*;
#(
    parameter int DW        = 16,
    parameter int DEPTH     = 512,
    parameter int LO_W      = 8,
    parameter int THR_RESET = 128,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int TW       = LO_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [1:0]      cfg_mode,
    input  logic            cfg_wm_hi,
    input  logic [LO_W-1:0] cfg_samples,
    input  logic            wr_valid,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_req,
    output logic [DW-1:0]   rd_data,
    output logic            ready,
    output logic            watermark,
    output logic            overrun
);
    fifo_state_t   state_w;
    logic [AW-1:0] wr_ptr_w, rd_ptr_w;
    logic [CW-1:0] count_w;
    logic          mem_we_w;
    logic [TW-1:0] thr_w;

    // Threshold register: high bit and low count loaded together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_w <= TW'(THR_RESET);
        end else if (cfg_wr) begin
            thr_w <= {cfg_wm_hi, cfg_samples};
        end
    end

    sample_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_mode (cfg_mode),
        .wr_valid (wr_valid),
        .rd_req   (rd_req),
        .state    (state_w),
        .wr_ptr   (wr_ptr_w),
        .rd_ptr   (rd_ptr_w),
        .count    (count_w),
        .mem_we   (mem_we_w),
        .overrun  (overrun)
    );

    sample_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we_w),
        .waddr (wr_ptr_w),
        .wdata (wr_data),
        .raddr (rd_ptr_w),
        .rdata (rd_data)
    );

    sample_fifo_flags #(.DEPTH(DEPTH), .TW(TW)) u_flags (
        .state     (state_w),
        .count     (count_w),
        .thr       (thr_w),
        .ready     (ready),
        .watermark (watermark)
    );
endmodule

// File: rtl/sample_fifo_chk.sv
module sample_fifo_chk #(
    parameter int TW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic [1:0]    cfg_mode,
    input logic          wr_valid,
    input logic          rd_req,
    input logic          ready,
    input logic          watermark,
    input logic          overrun,
    input logic [TW-1:0] thr
);
    p_ready_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(wr_valid));

    p_zero_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == '0) |-> watermark);

    p_overrun_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(wr_valid) && !$past(rd_req && ready)));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && ready) |=> !overrun);

    p_off_flushes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_mode == 2'b00) |=> ##1 (!ready && !overrun));
endmodule

bind sample_fifo sample_fifo_chk #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_mode  (cfg_mode),
    .wr_valid  (wr_valid),
    .rd_req    (rd_req),
    .ready     (ready),
    .watermark (watermark),
    .overrun   (overrun),
    .thr       (thr_w)
);

// File: tb/sim_sample_fifo.sv
module sim_sample_fifo;
    localparam int DW    = 16;
    localparam int DEPTH = 512;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_wr;
    logic [1:0]    cfg_mode;
    logic          cfg_wm_hi;
    logic [7:0]    cfg_samples;
    logic          wr_valid;
    logic [DW-1:0] wr_data;
    logic          rd_req;
    logic [DW-1:0] rd_data;
    logic          ready, watermark, overrun;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    sample_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_wm_hi(cfg_wm_hi), .cfg_samples(cfg_samples),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
        .rd_data(rd_data), .ready(ready), .watermark(watermark),
        .overrun(overrun)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    logic [DW-1:0] q[$];
    int            m_mode;
    int            m_thr;
    bit            m_ovr;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_mode = 0;
            m_thr  = 128;
            m_ovr  = 0;
        end else begin
            bit rdk;
            if (m_mode == 0) begin
                q.delete();
                m_ovr = 0;
            end else begin
                rdk = rd_req && (q.size() != 0);
                if (rdk) begin
                    void'(q.pop_front());
                    m_ovr = 0;
                end
                if (wr_valid) begin
                    if (q.size() < DEPTH) begin
                        q.push_back(wr_data);
                    end else begin
                        m_ovr = 1;
                        if (m_mode == 1 || m_mode == 3) begin
                            void'(q.pop_front());
                            q.push_back(wr_data);
                        end
                    end
                end
            end
            if (cfg_wr) begin
                m_mode = int'(cfg_mode);
                m_thr  = int'({cfg_wm_hi, cfg_samples});
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit er;
            er = (q.size() != 0) && (m_mode != 0);
            chk(cur_req, "ready R2", 32'(ready), 32'(er));
            chk(cur_req, "watermark R4", 32'(watermark), 32'(q.size() >= m_thr));
            chk(cur_req, "overrun", 32'(overrun), 32'(m_ovr));
            if (er) chk(cur_req, "rd_data R3", 32'(rd_data), 32'(q[0]));
        end
    end

    task automatic cfg(input logic [1:0] m, input logic hi, input logic [7:0] s);
        cfg_wr = 1'b1; cfg_mode = m; cfg_wm_hi = hi; cfg_samples = s;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic push(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1; wr_data = base + DW'(i);
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic pop(input int n);
        for (int i = 0; i < n; i++) begin
            rd_req = 1'b1;
            @(negedge clk);
        end
        rd_req = 1'b0;
    endtask

    task automatic both(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            rd_req = 1'b1; wr_valid = 1'b1; wr_data = base + DW'(i);
            @(negedge clk);
        end
        rd_req = 1'b0; wr_valid = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_mode = 2'b00; cfg_wm_hi = 1'b0;
        cfg_samples = 8'h00; wr_valid = 1'b0; wr_data = '0; rd_req = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ready", 32'(ready), 0);
        chk("R1", "watermark", 32'(watermark), 0);
        chk("R1", "overrun", 32'(overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);
        push(130, 16'h0050);   // R10: ignored while off
        chk("R10", "ready while off", 32'(ready), 0);
        chk("R1", "watermark with default threshold", 32'(watermark), 0);

        // R4 / R11: streaming, threshold 5
        cur_req = "R4";
        cfg(2'b01, 1'b0, 8'd5);
        push(4, 16'h0100);
        chk("R4", "below threshold", 32'(watermark), 0);
        push(1, 16'h0104);
        chk("R4", "at threshold", 32'(watermark), 1);
        push(2, 16'h0105);
        pop(2);
        chk("R4", "still at threshold", 32'(watermark), 1);
        pop(1);
        chk("R4", "self clear below", 32'(watermark), 0);
        chk("R3", "oldest after 3 reads", 32'(rd_data), 32'h0103);

        // R5: threshold zero
        cur_req = "R5";
        cfg(2'b01, 1'b0, 8'd0);
        pop(4);
        chk("R2", "empty ready", 32'(ready), 0);
        chk("R5", "zero threshold on empty", 32'(watermark), 1);

        // R6: streaming overflow, threshold 511 uses the high bit
        cur_req = "R6";
        cfg(2'b01, 1'b1, 8'hFF);
        push(510, 16'h1000);
        chk("R4", "510 below 511", 32'(watermark), 0);
        push(2, 16'h1000 + 16'd510);
        chk("R4", "full above 511", 32'(watermark), 1);
        chk("R6", "no overrun at exactly full", 32'(overrun), 0);
        push(3, 16'h2000);
        chk("R6", "overrun set", 32'(overrun), 1);
        chk("R6", "oldest three dropped", 32'(rd_data), 32'h1003);

        cur_req = "R9";
        pop(1);
        chk("R9", "read clears overrun", 32'(overrun), 0);

        cur_req = "R8";
        push(1, 16'h2100);
        both(4, 16'h2200);
        chk("R8", "read+write on full", 32'(overrun), 0);
        chk("R8", "head advanced", 32'(rd_data), 32'h1008);

        // R10: disable while data stored and overrun set
        cur_req = "R10";
        push(1, 16'h2300);
        chk("R6", "overrun before disable", 32'(overrun), 1);
        cfg(2'b00, 1'b1, 8'h00);
        @(negedge clk);
        chk("R10", "overrun flushed", 32'(overrun), 0);
        chk("R10", "ready flushed", 32'(ready), 0);
        push(3, 16'h2400);
        pop(2);
        chk("R10", "traffic ignored while off", 32'(ready), 0);

        // R7: oldest-saved overflow
        cur_req = "R7";
        cfg(2'b10, 1'b1, 8'hFF);
        chk("R10", "re-enabled queue empty", 32'(ready), 0);
        push(DEPTH, 16'h3000);
        push(2, 16'h4000);
        chk("R7", "overrun set", 32'(overrun), 1);
        chk("R7", "head kept", 32'(rd_data), 32'h3000);
        pop(DEPTH - 1);
        chk("R7", "last kept sample", 32'(rd_data), 32'h3000 + DEPTH - 1);
        pop(1);
        chk("R7", "new samples never stored", 32'(ready), 0);

        // R11: encoding 2'b11 behaves as streaming
        cur_req = "R11";
        cfg(2'b11, 1'b0, 8'd2);
        push(DEPTH + 1, 16'h5000);
        chk("R11", "11 overwrites oldest", 32'(rd_data), 32'h5001);
        chk("R11", "overrun in mode 11", 32'(overrun), 1);
        pop(3);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule